// File: doc/BRIEF.md
# Run-time Configurable Serial Transmit Frontend

This block turns one character into an asynchronous serial frame on a single output line. A character is offered on a valid/ready input. When it is taken, the block latches the character, the frame format and the bit-period divider. It then drives, in order, a low start bit, the data bits with the least significant bit first, an optional parity bit, and one or two high stop bits. The line is high whenever no frame is in progress.

The frame format is chosen separately for each frame. There are three format controls: a 7- or 8-bit character, parity off, even or odd, and one or two stop bits, which give twelve formats. Every bit lasts a programmable number of system clock cycles. A cancel input abandons the frame at once. The surrounding logic raises cancel whenever it rewrites the configuration. Buffering and the bus-side register interface belong to the neighbouring blocks.

The input has no back-pressure apart from the frame itself. `in_ready` is high only when no frame is running and `cancel` is low. A character is taken on the rising clock edge where `in_valid` and `in_ready` are both high. It is never taken while a frame is running. A source may keep `in_valid` high through a frame, and the next character is then taken when the line is free again.

Top module: `uart_tx_frontend`

## Requirements
- R1: While `rst` is high, and after the first clock edge with `rst` high, `tx` is 1, `busy` is 0, `done` is 0, and `in_ready` is 1 once `rst` falls.
- R2: `in_ready` equals (not `busy`) and (not `cancel`). A character is taken only on an edge where `in_valid` and `in_ready` are both 1. Holding `in_valid` high during a frame starts nothing.
- R3: A frame starts with one low bit on the edge where the character is taken. The data bits follow, least significant first. The frame ends with high stop bits, and `tx` is 1 whenever `busy` is 0.
- R4: `cfg_wide`=1 sends DATA_W data bits. `cfg_wide`=0 sends DATA_W-1 bits, and the top bit of `in_data` has no effect on the line.
- R5: `cfg_parity` selects the parity bit: 2'b00 sends none, 2'b01 sends the XOR of the sent data bits (even), 2'b10 sends its inverse (odd), and 2'b11 behaves as 2'b00. A parity bit comes right after the last data bit.
- R6: `cfg_two_stop`=0 sends one stop bit and `cfg_two_stop`=1 sends two.
- R7: Each bit lasts exactly `divider` clock cycles. A `divider` of 0 behaves as 1.
- R8: `busy` is high from the edge where the character is taken until the edge that ends the last stop bit. On that edge `done` pulses high for exactly one cycle.
- R9: When `cancel` is 1 during a frame, the next edge returns `busy` to 0 and `tx` to 1, and no `done` pulse follows.
- R10: The character, the format controls and `divider` are captured when the character is taken. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Block can take a character |
| in_data | input | DATA_W | Character to send, LSB first |
| cfg_wide | input | 1 | 1: DATA_W data bits, 0: DATA_W-1 |
| cfg_parity | input | 2 | 00 none, 01 even, 10 odd, 11 none |
| cfg_two_stop | input | 1 | 1: two stop bits |
| divider | input | DIV_W | Clock cycles per bit (0 acts as 1) |
| cancel | input | 1 | Abandon the current frame |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at end of frame |
| tx | output | 1 | Serial output line |

## Verification
The bench builds the block with DATA_W=8 and DIV_W=16. With 8 bits, the short format drops a real top bit, so a character with bit 7 set shows whether that bit leaks onto the line. The bench runs the twelve formats at divider values of 0, 1 and up to 5. This places every bit boundary, and the edge that ends the last stop bit, at cycle counts the bench can check one by one. A 16-bit divider field allows slow rates, but the bench keeps the values small so that every frame is checked cycle by cycle.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_EVEN = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_RSVD = 2'b11
  } parity_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } frame_state_e;
endpackage

// File: rtl/uart_tx_bit_timer.sv
module uart_tx_bit_timer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             run,
  input  logic [DIV_W-1:0] divider,
  output logic             tick
);
  logic [DIV_W-1:0] limit_q;
  logic [DIV_W-1:0] count_q;

  assign tick = run && (count_q >= limit_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      limit_q <= '0;
      count_q <= '0;
    end else if (load) begin
      limit_q <= (divider == '0) ? '0 : divider - DIV_W'(1);
      count_q <= '0;
    end else if (!run || tick) begin
      count_q <= '0;
    end else begin
      count_q <= count_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/uart_tx_parity.sv
module uart_tx_parity
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic              wide,
  input  logic [1:0]        mode,
  output logic              enable,
  output logic              value
);
  logic [DATA_W-1:0] used;

  always_comb begin
    used = data;
    if (!wide) used[DATA_W-1] = 1'b0;
    enable = (mode == PAR_EVEN) || (mode == PAR_ODD);
    value  = (^used) ^ (mode == PAR_ODD);
  end
endmodule

// File: rtl/uart_tx_sequencer.sv
module uart_tx_sequencer
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              abort,
  input  logic              tick,
  input  logic [DATA_W-1:0] data,
  input  logic              wide,
  input  logic              par_en,
  input  logic              par_val,
  input  logic              two_stop,
  output logic              busy,
  output logic              done,
  output logic              tx
);
  localparam int IDX_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;

  frame_state_e      state_q;
  logic [DATA_W-1:0] shift_q;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  last_q;
  logic              par_en_q;
  logic              par_q;
  logic              two_stop_q;
  logic              stop_idx_q;

  assign busy = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      shift_q    <= '0;
      idx_q      <= '0;
      last_q     <= '0;
      par_en_q   <= 1'b0;
      par_q      <= 1'b0;
      two_stop_q <= 1'b0;
      stop_idx_q <= 1'b0;
      done       <= 1'b0;
      tx         <= 1'b1;
    end else begin
      done <= 1'b0;
      if (busy && abort) begin
        state_q <= ST_IDLE;
        tx      <= 1'b1;
      end else begin
        unique case (state_q)
          ST_IDLE: if (go) begin
            state_q    <= ST_START;
            shift_q    <= data;
            last_q     <= wide ? IDX_W'(DATA_W - 1) : IDX_W'(DATA_W - 2);
            par_en_q   <= par_en;
            par_q      <= par_val;
            two_stop_q <= two_stop;
            tx         <= 1'b0;
          end
          ST_START: if (tick) begin
            state_q <= ST_DATA;
            idx_q   <= '0;
            tx      <= shift_q[0];
            shift_q <= shift_q >> 1;
          end
          ST_DATA: if (tick) begin
            if (idx_q == last_q) begin
              if (par_en_q) begin
                state_q <= ST_PARITY;
                tx      <= par_q;
              end else begin
                state_q    <= ST_STOP;
                stop_idx_q <= 1'b0;
                tx         <= 1'b1;
              end
            end else begin
              idx_q   <= idx_q + IDX_W'(1);
              tx      <= shift_q[0];
              shift_q <= shift_q >> 1;
            end
          end
          ST_PARITY: if (tick) begin
            state_q    <= ST_STOP;
            stop_idx_q <= 1'b0;
            tx         <= 1'b1;
          end
          ST_STOP: if (tick) begin
            if (stop_idx_q == two_stop_q) begin
              state_q <= ST_IDLE;
              done    <= 1'b1;
            end else begin
              stop_idx_q <= 1'b1;
            end
          end
          default: begin
            state_q <= ST_IDLE;
            tx      <= 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_tx_frontend.sv
module uart_tx_frontend
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              cfg_wide,
  input  logic [1:0]        cfg_parity,
  input  logic              cfg_two_stop,
  input  logic [DIV_W-1:0]  divider,
  input  logic              cancel,
  output logic              busy,
  output logic              done,
  output logic              tx
);
  logic accept;
  logic tick;
  logic par_en;
  logic par_val;

  assign in_ready = !busy && !cancel;
  assign accept   = in_valid && in_ready;

  uart_tx_parity #(.DATA_W(DATA_W)) u_parity (
    .data   (in_data),
    .wide   (cfg_wide),
    .mode   (cfg_parity),
    .enable (par_en),
    .value  (par_val)
  );

  uart_tx_bit_timer #(.DIV_W(DIV_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (accept),
    .run     (busy),
    .divider (divider),
    .tick    (tick)
  );

  uart_tx_sequencer #(.DATA_W(DATA_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .go       (accept),
    .abort    (cancel),
    .tick     (tick),
    .data     (in_data),
    .wide     (cfg_wide),
    .par_en   (par_en),
    .par_val  (par_val),
    .two_stop (cfg_two_stop),
    .busy     (busy),
    .done     (done),
    .tx       (tx)
  );
endmodule

// File: rtl/uart_tx_frontend_checker.sv
module uart_tx_frontend_checker (
  input logic clk,
  input logic rst,
  input logic cancel,
  input logic in_valid,
  input logic in_ready,
  input logic busy,
  input logic done,
  input logic tx
);
  p_ready_blocked_r2: assert property (@(posedge clk) disable iff (rst)
    busy |-> !in_ready);

  p_idle_high_r3: assert property (@(posedge clk) disable iff (rst)
    !busy |-> tx);

  p_start_low_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !tx);

  p_take_starts_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> busy);

  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_ends_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> $fell(busy));

  p_cancel_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && cancel) |=> (!busy && !done && tx));
endmodule

bind uart_tx_frontend uart_tx_frontend_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .cancel   (cancel),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .busy     (busy),
  .done     (done),
  .tx       (tx)
);

// File: tb/uart_tx_frontend_tb.sv
module uart_tx_frontend_tb;
  localparam int DATA_W = 8;
  localparam int DIV_W  = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [DATA_W-1:0] in_data = '0;
  logic              cfg_wide = 1'b1;
  logic [1:0]        cfg_parity = 2'b00;
  logic              cfg_two_stop = 1'b0;
  logic [DIV_W-1:0]  divider = 16'd4;
  logic              cancel = 1'b0;
  logic              busy;
  logic              done;
  logic              tx;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  uart_tx_frontend #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .cfg_wide(cfg_wide), .cfg_parity(cfg_parity),
    .cfg_two_stop(cfg_two_stop), .divider(divider), .cancel(cancel),
    .busy(busy), .done(done), .tx(tx)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Sends one frame and checks every cycle of it against a frame built here.
  task automatic send_frame(input logic [7:0] data, input bit wide,
                            input logic [1:0] par, input bit two,
                            input int div, input string tag);
    bit bits[16];
    int n = 0;
    int nd = wide ? 8 : 7;
    int d = (div == 0) ? 1 : div;
    logic p = 1'b0;
    int bad = 0, bad_c = -1, bad_act = 0, bad_exp = 0, side = 0;
    bits[n++] = 1'b0;
    for (int i = 0; i < nd; i++) begin
      bits[n++] = data[i];
      p ^= data[i];
    end
    if (par == 2'b01) bits[n++] = p;
    if (par == 2'b10) bits[n++] = ~p;
    bits[n++] = 1'b1;
    if (two) bits[n++] = 1'b1;

    @(negedge clk);
    in_data = data; cfg_wide = wide; cfg_parity = par;
    cfg_two_stop = two; divider = DIV_W'(div); in_valid = 1'b1;
    check(in_ready == 1'b1, "R2", {tag, " ready before offer"}, int'(in_ready), 1);
    @(posedge clk);
    @(negedge clk);
    // R10: scramble every latched input; R2: keep offering during the frame
    in_data = ~data; cfg_wide = ~wide; cfg_parity = par + 2'b01;
    cfg_two_stop = ~two; divider = DIV_W'(d + 3);
    for (int c = 0; c < n * d; c++) begin
      if (tx !== bits[c / d]) begin
        if (bad == 0) begin bad_c = c; bad_act = int'(tx); bad_exp = int'(bits[c / d]); end
        bad++;
      end
      if (busy !== 1'b1 || in_ready !== 1'b0 || done !== 1'b0) side++;
      if (c == n * d - 1) in_valid = 1'b0;
      @(negedge clk);
    end
    check(bad == 0, "R3/R4/R5/R6/R7/R10",
          $sformatf("%s line bit mismatch at cycle %0d", tag, bad_c), bad_act, bad_exp);
    check(side == 0, "R2/R8", {tag, " busy/ready during frame"}, side, 0);
    check(done == 1'b1 && busy == 1'b0 && tx == 1'b1, "R8",
          {tag, " done at end of last stop"}, int'({done, busy, tx}), 5);
    @(negedge clk);
    check(done == 1'b0 && in_ready == 1'b1, "R8", {tag, " done one cycle"},
          int'({done, in_ready}), 1);
  endtask

  task automatic t_reset;
    // R1
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(tx == 1'b1 && busy == 1'b0 && done == 1'b0, "R1", "reset outputs",
          int'({tx, busy, done}), 4);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1 && tx == 1'b1, "R1", "idle after reset",
          int'({in_ready, tx}), 3);
  endtask

  task automatic t_formats;
    // R3 R4 R5 R6 R7: main formats and divider boundaries
    send_frame(8'hA5, 1'b1, 2'b00, 1'b0, 4, "8N1 div4");
    send_frame(8'hD3, 1'b0, 2'b01, 1'b0, 3, "7E1 top bit set R4");
    send_frame(8'h6E, 1'b1, 2'b10, 1'b1, 5, "8O2 div5");
    send_frame(8'hFF, 1'b0, 2'b10, 1'b1, 2, "7O2 all ones");
    send_frame(8'h00, 1'b1, 2'b01, 1'b1, 1, "8E2 div1 R7");
    send_frame(8'h81, 1'b0, 2'b00, 1'b0, 0, "7N1 div0 R7");
    send_frame(8'h3C, 1'b1, 2'b11, 1'b0, 3, "reserved parity R5");
    for (int f = 0; f < 12; f++) begin
      send_frame(8'(8'h17 * (f + 3)), f[0], 2'(f / 4), f[1], 2 + f % 3,
                 $sformatf("format %0d", f));
    end
  endtask

  task automatic t_cancel;
    int seen = 0;
    // R9: abort mid-frame
    @(negedge clk);
    in_data = 8'h55; cfg_wide = 1'b1; cfg_parity = 2'b01; cfg_two_stop = 1'b1;
    divider = 16'd4; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (6) @(negedge clk);
    cancel = 1'b1;
    check(in_ready == 1'b0, "R2", "ready low under cancel", int'(in_ready), 0);
    @(negedge clk);
    cancel = 1'b0;
    check(busy == 1'b0 && tx == 1'b1 && done == 1'b0, "R9", "cancel ends frame",
          int'({busy, tx, done}), 2);
    for (int c = 0; c < 60; c++) begin
      if (done || !tx || busy) seen++;
      @(negedge clk);
    end
    check(seen == 0, "R9", "no done or line activity after cancel", seen, 0);
    // R2: cancel blocks a take while idle
    in_valid = 1'b1; cancel = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; cancel = 1'b0;
    check(busy == 1'b0 && tx == 1'b1, "R2", "no take while cancel high",
          int'({busy, tx}), 1);
    send_frame(8'h96, 1'b1, 2'b10, 1'b0, 3, "after cancel R9");
  endtask

  initial begin
    t_reset();
    t_formats();
    t_cancel();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule